// File: doc/BRIEF.md
# Pending Decision Tracker

This block counts how many first-level trigger accepts are still waiting for a second-level decision. Every accept pulse raises the count by one and every decision pulse lowers it by one. Both pulses are sampled on the tick clock, and each one both sets the direction of the count and enables it. The count is five bits wide. In normal running it stays between 0 and 16, but every value from 0 to 31 can be represented. At either end it saturates instead of wrapping.

Four programmable threshold flags watch the count. Each flag is registered and goes high when the count is strictly above its own five-bit limit. A small 16-bit register interface holds four things: the four limits, an enable for the timing-signal reset, a write-triggered forced clear, and a read-only monitor word that packs the count together with the four flags.

Top module: `pending_decision_tracker`

## Requirements
- R1: On a tick where `accept_i` is 1, `decision_i` is 0 and no clear occurs, the count rises by one, unless it is already 31.
- R2: On a tick where `decision_i` is 1, `accept_i` is 0 and no clear occurs, the count falls by one, unless it is already 0.
- R3: When `accept_i` and `decision_i` are both 1 on the same tick, the count keeps its value.
- R4: The count saturates at 31: a further accept on its own leaves it at 31.
- R5: The count saturates at 0: a further decision on its own leaves it at 0.
- R6: A tick with `tsr_strobe_i` at 1 clears the count to 0 only when bit 0 of the register at address 2 is 1. When that bit is 0, the strobe has no effect. Address 2 reads back this bit in bit 0 and reads 0 in all other bits.
- R7: A write to address 3 with data bit 0 set clears the count on the tick of the write. A write there with bit 0 clear changes nothing. Address 3 always reads 0.
- R8: Flag i (`flag_o[i]`) is 1 exactly when the count on the previous tick was strictly greater than limit i as it stood on that tick. The flag therefore lags the count by one tick.
- R9: The limits are stored as follows: limit 0 in bits 4:0 and limit 1 in bits 12:8 of address 8, and limit 2 and limit 3 in the same positions of address 9. Reading these addresses returns the stored limits, with bits 7:5 and 15:13 reading 0.
- R10: Address 12 reads the monitor word: the count in bits 4:0, zeros in bits 7:5, flags 3:0 in bits 11:8, and zeros in bits 15:12. Writes to address 12 have no effect.
- R11: After reset the count, the flags, the limits and the timing-reset enable are all 0. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | First-level accept pulse; counts up |
| decision_i | input | 1 | Second-level decision pulse; counts down |
| tsr_strobe_i | input | 1 | Timing-signal reset strobe; honoured only when enabled |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address for both read and write |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i`, combinational |
| count_o | output | 5 | Current outstanding count |
| flag_o | output | 4 | Registered threshold flags |

## Verification
The hardest situations to reach from the ports are the two saturation edges and the equality boundary of the flags. The stimulus pushes the count up to 31 with forty accepts in a row and then runs it down past 0 with forty decisions. Along the way, limits are set at 31 and at 30, which shows that a flag stays low when the count equals its limit and rises only when the count goes one above it. The clear paths are also driven against competing accepts on the same tick, so that the priority of a clear over a count is exercised, and the timing strobe is sent both with the enable off and with it on.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int CNT_W      = 5;
  localparam int A_TSR_EN   = 2;
  localparam int A_FORCE    = 3;
  localparam int A_THR_BASE = 8;
  localparam int A_MON      = 12;
  localparam int THR_STRIDE = 8;
  localparam int FLAG_LSB   = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

  // Saturating one-step move of the count; both or neither request holds it.
  function automatic cnt_t sat_step(cnt_t c, logic up, logic dn);
    cnt_t n;
    n = c;
    if (up && !dn && c != CNT_MAX) n = c + cnt_t'(1);
    else if (dn && !up && c != '0) n = c - cnt_t'(1);
    return n;
  endfunction

  // Strict greater-than test used by every threshold flag.
  function automatic logic above_limit(cnt_t c, cnt_t lim);
    return c > lim;
  endfunction
endpackage

// File: rtl/pdt_counter.sv
module pdt_counter
  import pdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output cnt_t count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else           count <= sat_step(count, inc, dec);
  end
endmodule

// File: rtl/pdt_compare.sv
module pdt_compare
  import pdt_pkg::*;
#(
  parameter int NUM_CMP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cnt_t                          count,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] limits,
  output logic [NUM_CMP-1:0]            flags
);
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= above_limit(count, limits[g]);
    end
  end
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  cnt_t                          count,
  input  logic [NUM_CMP-1:0]            flags,
  output logic [DATA_W-1:0]             rdata,
  output logic                          tsr_en,
  output logic                          force_clr,
  output logic [NUM_CMP-1:0][CNT_W-1:0] limits
);
  localparam int PER_REG = DATA_W / THR_STRIDE;

  function automatic logic [ADDR_W-1:0] thr_addr(int idx);
    return ADDR_W'(A_THR_BASE + idx / PER_REG);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_en <= 1'b0;
      limits <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_TSR_EN)) tsr_en <= wdata[0];
      for (int i = 0; i < NUM_CMP; i++) begin
        if (addr == thr_addr(i))
          limits[i] <= wdata[(i % PER_REG) * THR_STRIDE +: CNT_W];
      end
    end
  end

  assign force_clr = wr_en && (addr == ADDR_W'(A_FORCE)) && wdata[0];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_TSR_EN)) rdata[0] = tsr_en;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (addr == thr_addr(i))
        rdata[(i % PER_REG) * THR_STRIDE +: CNT_W] = limits[i];
    end
    if (addr == ADDR_W'(A_MON)) begin
      rdata[CNT_W-1:0]             = count;
      rdata[FLAG_LSB +: NUM_CMP]   = flags;
    end
  end
endmodule

// File: rtl/pending_decision_tracker.sv
module pending_decision_tracker
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              decision_i,
  input  logic              tsr_strobe_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [NUM_CMP-1:0] flag_o
);
  logic                          tsr_en;
  logic                          force_clr;
  logic                          tsr_clr;
  logic                          clr_evt;
  logic [NUM_CMP-1:0][CNT_W-1:0] limits;
  cnt_t                          count;

  assign tsr_clr = tsr_strobe_i && tsr_en;
  assign clr_evt = tsr_clr || force_clr;

  pdt_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (accept_i),
    .dec   (decision_i),
    .clr   (clr_evt),
    .count (count)
  );

  pdt_compare #(.NUM_CMP(NUM_CMP)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (count),
    .limits (limits),
    .flags  (flag_o)
  );

  pdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .wdata     (wdata_i),
    .count     (count),
    .flags     (flag_o),
    .rdata     (rdata_o),
    .tsr_en    (tsr_en),
    .force_clr (force_clr),
    .limits    (limits)
  );

  assign count_o = count;
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          accept_i,
  input logic                          decision_i,
  input logic                          tsr_strobe_i,
  input logic                          tsr_en,
  input logic                          force_clr,
  input logic                          clr_evt,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             rdata_o,
  input logic [CNT_W-1:0]              count_o,
  input logic [NUM_CMP-1:0]            flag_o,
  input logic [NUM_CMP-1:0][CNT_W-1:0] limits
);
  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !decision_i && !clr_evt && count_o != CNT_MAX)
      |=> count_o == $past(count_o) + CNT_W'(1));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_i && !accept_i && !clr_evt && count_o != '0)
      |=> count_o == $past(count_o) - CNT_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && decision_i && !clr_evt) |=> $stable(count_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clr_evt) |=> count_o != '0);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !clr_evt && !accept_i) |=> count_o == '0);

  p_tsr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tsr_strobe_i && tsr_en) |=> count_o == '0);

  p_force_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> count_o == '0);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_flag
    p_flag_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> flag_o[g] == ($past(count_o) > $past(limits[g])));
  end

  p_thr_rsv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(A_THR_BASE) || addr_i == ADDR_W'(A_THR_BASE + 1))
      |-> (rdata_o[7:5] == 3'b0 && rdata_o[15:13] == 3'b0));

  p_monitor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(A_MON))
      |-> (rdata_o[4:0] == count_o && rdata_o[11:8] == flag_o
           && rdata_o[7:5] == 3'b0 && rdata_o[15:12] == 4'b0));
endmodule

bind pending_decision_tracker pdt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CMP(NUM_CMP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept_i     (accept_i),
  .decision_i   (decision_i),
  .tsr_strobe_i (tsr_strobe_i),
  .tsr_en       (tsr_en),
  .force_clr    (force_clr),
  .clr_evt      (clr_evt),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .count_o      (count_o),
  .flag_o       (flag_o),
  .limits       (limits)
);

// File: tb/pending_decision_tracker_bench.sv
module pending_decision_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic        decision_i = 1'b0;
  logic        tsr_strobe_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [4:0]  count_o;
  logic [3:0]  flag_o;

  always #5 clk = ~clk;

  pending_decision_tracker u_pending_decision_tracker (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .decision_i(decision_i),
    .tsr_strobe_i(tsr_strobe_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .count_o(count_o), .flag_o(flag_o)
  );

  typedef struct {
    logic [4:0] cnt;
    logic [3:0] flg;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Reference model state
  int   m_cnt = 0;
  int   m_thr[4] = '{0, 0, 0, 0};
  bit   m_en = 0;
  logic [3:0] m_flg = '0;

  task automatic report(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per tick and compares the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      report({e.tag, " count"}, int'(count_o), int'(e.cnt));
      report({e.tag, " flags"}, int'(flag_o), int'(e.flg));
    end
  end

  // Driver: one tick of stimulus, model update, expectation push
  task automatic step(bit acc, bit dec, bit tsr, bit wr, int adr, int wd, string tag);
    exp_t e;
    @(negedge clk);
    accept_i = acc; decision_i = dec; tsr_strobe_i = tsr;
    wr_en_i = wr; addr_i = 6'(adr); wdata_i = 16'(wd);
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) m_flg[i] = (m_cnt > m_thr[i]);
    if ((tsr && m_en) || (wr && adr == 3 && wd[0])) m_cnt = 0;
    else if (acc && !dec && m_cnt < 31) m_cnt++;
    else if (dec && !acc && m_cnt > 0) m_cnt--;
    if (wr && adr == 2) m_en = wd[0];
    if (wr && adr == 8) begin m_thr[0] = wd & 31; m_thr[1] = (wd >> 8) & 31; end
    if (wr && adr == 9) begin m_thr[2] = wd & 31; m_thr[3] = (wd >> 8) & 31; end
    accept_i = 0; decision_i = 0; tsr_strobe_i = 0; wr_en_i = 0;
    e.cnt = 5'(m_cnt); e.flg = m_flg; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd_check(int adr, int exp, string tag);
    @(negedge clk);
    addr_i = 6'(adr); wr_en_i = 0;
    #1;
    report(tag, int'(rdata_o), exp);
  endtask

  function automatic int mon_word();
    return (int'(m_flg) << 8) | m_cnt;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: reset state
    rd_check(12, 0, "R11 monitor after reset");
    rd_check(8, 0, "R11 limits after reset");
    rd_check(2, 0, "R11 enable after reset");
    rd_check(20, 0, "R11 unmapped read");
    report("R11 count after reset", int'(count_o), 0);
    report("R11 flags after reset", int'(flag_o), 0);

    // R9: limit fields and reserved bits
    step(0, 0, 0, 1, 8, 16'hE5E5, "R9 write lim01");
    rd_check(8, 16'h0505, "R9 reserved bits read zero");
    step(0, 0, 0, 1, 8, 16'h0402, "R9 write lim01");
    step(0, 0, 0, 1, 9, 16'h1F10, "R9 write lim23");
    rd_check(8, 16'h0402, "R9 readback lim01");
    rd_check(9, 16'h1F10, "R9 readback lim23");

    // R1 and R8: count up, flags follow one tick later
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, "R1 accept");
    step(0, 0, 0, 0, 0, 0, "R8 flag settle");
    report("R1 count after five accepts", int'(count_o), 5);
    report("R8 flags at count 5 lim 2/4/16/31", int'(flag_o), 4'b0011);
    rd_check(12, 16'h0305, "R10 monitor word");

    // R3: simultaneous pulses hold
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, "R3 both");
    // R2: count down
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, 0, "R2 decision");
    report("R2 count after two decisions", int'(count_o), 3);

    // R4: saturate high, flag equality boundary
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, 0, "R4 accept run");
    step(0, 0, 0, 0, 0, 0, "R4 settle");
    report("R4 saturated count", int'(count_o), 31);
    report("R8 count equal to limit 3 leaves flag low", int'(flag_o[3]), 0);
    step(0, 0, 0, 1, 9, 16'h1E10, "R8 lower lim3 to 30");
    step(0, 0, 0, 0, 0, 0, "R8 settle");
    report("R8 flag3 high above limit 30", int'(flag_o[3]), 1);

    // R10: write to monitor ignored
    step(0, 0, 0, 1, 12, 16'h0000, "R10 write monitor");
    rd_check(12, mon_word(), "R10 monitor after ignored write");

    // R5: saturate low
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 0, 0, "R5 decision run");
    report("R5 saturated count", int'(count_o), 0);

    // R6: timing strobe gated
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, "R6 refill");
    step(0, 0, 1, 0, 0, 0, "R6 strobe disabled");
    report("R6 strobe ignored when disabled", int'(count_o), 6);
    step(0, 0, 0, 1, 2, 16'hFFFF, "R6 enable");
    rd_check(2, 1, "R6 enable readback");
    step(1, 0, 1, 0, 0, 0, "R6 strobe enabled with accept");
    report("R6 strobe clears", int'(count_o), 0);

    // R7: forced clear
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R7 refill");
    step(0, 0, 0, 1, 3, 16'h0002, "R7 bit0 clear no effect");
    report("R7 write without bit0", int'(count_o), 4);
    rd_check(3, 0, "R7 force reg reads zero");
    step(1, 0, 0, 1, 3, 16'h0001, "R7 force clear with accept");
    report("R7 forced clear", int'(count_o), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule